// File: doc/BRIEF.md
# Serial Command Register Front End

This block gives a measurement controller a register port reached over a four-wire serial link: a serial clock, a data input, a data output and an active-low select. All four are sampled in the system clock domain. Each access starts with a command byte, which the first 1 bit on the data line marks. The command byte says whether the access reads or writes and which of 32 addresses it targets. The data phase follows at once, and its length depends on the address. When the data phase ends, the port waits for the next start bit, so commands can follow one another without the select being raised.

Behind the port sit five registers:
- a status byte with sticky event flags,
- a 16-bit control word that is brought out as a pin bus,
- two signed 16-bit thresholds,
- a 24-bit conversion result that arrives from a converter over a valid/ready stream.

A result is accepted only when no earlier result is waiting to be read. The ready signal is therefore the back-pressure path. A source that sees ready low must hold valid and data stable until a transfer occurs. Ready returns high when the result register is read over the serial port. The status flags record the sign of the held result, a threshold crossing on either side, and a low-battery condition. A status read clears a flag only if its condition has gone away.

Top module: `sercmd_regif`

## Requirements
- R1: While the port waits for a command, 0 bits on the data line are ignored. The first 1 sampled becomes bit 7 (the start bit) of the command byte.
- R2: In the command byte, bit 6 selects read (1) or write (0), bits 5..1 hold the address (MSB first), and bit 0 is ignored. The address map is: 0 status, 1 control, 2 over threshold, 3 under threshold, 4 result. Every other address reads as zero.
- R3: The data phase is 8 bits for status and for unmapped addresses, 16 bits for control and both thresholds, and 24 bits for the result. After the data phase the next 1 bit starts a new command.
- R4: The data line is sampled on rising serial clock edges. Read data is taken at the rising edge that completes the command byte. It is then driven MSB first, with a new bit after each falling edge, and is right-aligned within its data-phase width.
- R5: A write to control or to either threshold stores the 16 data bits. A write to status, result or an unmapped address changes no register.
- R6: After reset, control reads 0x0001 (bit 0 is the display enable), the thresholds, status and result read zero, the data output is 0 and result ready is 1.
- R7: The status byte is laid out as: bit 7 negative result, bit 6 over, bit 5 under, bit 4 low battery, bit 3 result ready, bits 2..0 zero.
- R8: A flag sets whenever its condition is true. The conditions are: the result's bit 23 for negative; result > over threshold for over; result < under threshold for under; the low-battery input for low battery. All comparisons are signed 24-bit, with the thresholds sign-extended.
- R9: A status read clears each of the four condition flags whose condition is false at the capture edge. A flag whose condition is true stays set.
- R10: The result-ready status bit sets when a result is accepted. Only a read of the result register clears it; a status read leaves it set.
- R11: result_ready is high exactly when no accepted result remains unread. A result transfers when result_valid and result_ready are both high.
- R12: Raising the select aborts any partial command or data phase. No write commits, the data output returns to 0 and the start-bit search begins again.
- R13: The ctrl_word output always equals the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock |
| csn | input | 1 | Active-low select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| result_valid | input | 1 | Conversion result offered |
| result_ready | output | 1 | Result register free to accept |
| result_data | input | 24 | Signed conversion result |
| lowbatt_cond | input | 1 | Low-battery condition |
| ctrl_word | output | 16 | Current control register |

## Verification
Every one of the 32 addresses is read with 0 to 7 leading idle zeros. Bit 0 of the command toggles between reads. Each read is followed at once by a control read, so a wrong data-phase length shows up as a misframed follow-up rather than passing unnoticed.

The flag logic is swept over signed results exactly at, one beyond and one short of both thresholds, plus the two 24-bit extremes. A bench model predicts each status byte arithmetically. Repeated status reads separate sticky-but-cleared flags from flags held by a live condition.

Writes to read-only and unmapped addresses, a blocked second result, and selects raised in the middle of the command and in the middle of the data phase separate real commits from ignored traffic.

// File: rtl/sif_pkg.sv
package sif_pkg;
  localparam int ADDR_W = 5;
  localparam int CTRL_W = 16;
  localparam int THR_W  = 16;
  localparam int RES_W  = 24;
  localparam int STAT_W = 8;
  localparam int SR_W   = RES_W;
  localparam int CNT_W  = $clog2(SR_W + 1);
  localparam int NFLAG  = 4;

  localparam logic [ADDR_W-1:0] A_STAT = 5'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 5'd1;
  localparam logic [ADDR_W-1:0] A_OVR  = 5'd2;
  localparam logic [ADDR_W-1:0] A_UND  = 5'd3;
  localparam logic [ADDR_W-1:0] A_RES  = 5'd4;

  localparam logic [CTRL_W-1:0] CTRL_RST = 16'h0001;

  typedef enum logic [1:0] {ST_HUNT, ST_CMD, ST_DATA} frame_st_e;

  function automatic logic [CNT_W-1:0] data_bits(input logic [ADDR_W-1:0] a);
    case (a)
      A_CTRL, A_OVR, A_UND: data_bits = CNT_W'(THR_W);
      A_RES:                data_bits = CNT_W'(RES_W);
      default:              data_bits = CNT_W'(STAT_W);
    endcase
  endfunction
endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
  parameter int STAGES = 2,
  parameter int W = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[g] <= RST;
      else if (g == 0) st[g] <= d;
      else st[g] <= st[(g == 0) ? 0 : g - 1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sif_frame.sv
module sif_frame
  import sif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              mosi_s,
  input  logic [SR_W-1:0]   rd_data,
  output logic              rd_stb,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [THR_W-1:0]  wr_data,
  output logic              miso
);
  frame_st_e         state_q;
  logic              sclk_d;
  logic [CNT_W-1:0]  cnt_q, bits_q;
  logic [ADDR_W:0]   cmd_sr;
  logic [THR_W-2:0]  in_sr;
  logic [SR_W-1:0]   out_sr;
  logic              rd_q, wr_en_q, miso_q;
  logic [ADDR_W-1:0] addr_q;
  logic [THR_W-1:0]  wr_data_q;
  logic              rise, fall, cmd_done;

  assign rise     = sclk_s & ~sclk_d;
  assign fall     = ~sclk_s & sclk_d;
  assign cmd_done = rise && !csn_s && state_q == ST_CMD && cnt_q == CNT_W'(7);
  assign rd_stb   = cmd_done && cmd_sr[ADDR_W];
  assign rd_addr  = cmd_sr[ADDR_W-1:0];
  assign wr_en    = wr_en_q;
  assign wr_addr  = addr_q;
  assign wr_data  = wr_data_q;
  assign miso     = miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_HUNT;
      sclk_d    <= 1'b0;
      cnt_q     <= '0;
      bits_q    <= '0;
      cmd_sr    <= '0;
      in_sr     <= '0;
      out_sr    <= '0;
      rd_q      <= 1'b0;
      addr_q    <= '0;
      wr_en_q   <= 1'b0;
      wr_data_q <= '0;
      miso_q    <= 1'b0;
    end else begin
      sclk_d  <= sclk_s;
      wr_en_q <= 1'b0;
      if (csn_s) begin
        state_q <= ST_HUNT;
        cnt_q   <= '0;
        miso_q  <= 1'b0;
      end else begin
        if (rise) begin
          case (state_q)
            ST_HUNT: if (mosi_s) begin
              state_q <= ST_CMD;
              cnt_q   <= CNT_W'(1);
            end
            ST_CMD: begin
              cmd_sr <= {cmd_sr[ADDR_W-1:0], mosi_s};
              cnt_q  <= cnt_q + 1'b1;
              if (cmd_done) begin
                state_q <= ST_DATA;
                cnt_q   <= '0;
                rd_q    <= cmd_sr[ADDR_W];
                addr_q  <= cmd_sr[ADDR_W-1:0];
                bits_q  <= data_bits(cmd_sr[ADDR_W-1:0]);
                out_sr  <= rd_data << (SR_W - int'(data_bits(cmd_sr[ADDR_W-1:0])));
              end
            end
            ST_DATA: begin
              in_sr <= {in_sr[THR_W-3:0], mosi_s};
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == bits_q - 1'b1) begin
                state_q   <= ST_HUNT;
                wr_en_q   <= !rd_q;
                wr_data_q <= {in_sr, mosi_s};
              end
            end
            default: state_q <= ST_HUNT;
          endcase
        end
        if (fall) begin
          if (state_q == ST_DATA && rd_q) begin
            miso_q <= out_sr[SR_W-1];
            out_sr <= out_sr << 1;
          end else begin
            miso_q <= 1'b0;
          end
        end
      end
    end
  end

  // R12
  csn_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> (state_q == ST_HUNT && !wr_en_q));
  // R3
  data_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (cnt_q < bits_q));
  // R5
  wr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> (!rd_q && $past(state_q) == ST_DATA));
endmodule

// File: rtl/sif_regfile.sv
module sif_regfile
  import sif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [SR_W-1:0]   rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [THR_W-1:0]  wr_data,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [RES_W-1:0]  res_data,
  input  logic              lowbatt,
  output logic [CTRL_W-1:0] ctrl
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [THR_W-1:0]  ovr_q, und_q;
  logic [RES_W-1:0]  res_q;
  logic              drdy_q;
  logic [NFLAG-1:0]  flg_q, cond_v;
  logic [RES_W-1:0]  ovr_ext, und_ext;
  logic              stat_rd, res_rd, accept;

  assign ovr_ext = {{(RES_W-THR_W){ovr_q[THR_W-1]}}, ovr_q};
  assign und_ext = {{(RES_W-THR_W){und_q[THR_W-1]}}, und_q};
  assign cond_v  = {res_q[RES_W-1],
                    $signed(res_q) > $signed(ovr_ext),
                    $signed(res_q) < $signed(und_ext),
                    lowbatt};
  assign stat_rd   = rd_stb && rd_addr == A_STAT;
  assign res_rd    = rd_stb && rd_addr == A_RES;
  assign res_ready = ~drdy_q;
  assign accept    = res_valid & ~drdy_q;
  assign ctrl      = ctrl_q;

  always_comb begin
    case (rd_addr)
      A_STAT:  rd_data = SR_W'({flg_q, drdy_q, 3'b000});
      A_CTRL:  rd_data = SR_W'(ctrl_q);
      A_OVR:   rd_data = SR_W'(ovr_q);
      A_UND:   rd_data = SR_W'(und_q);
      A_RES:   rd_data = res_q;
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      ovr_q  <= '0;
      und_q  <= '0;
      res_q  <= '0;
      drdy_q <= 1'b0;
      flg_q  <= '0;
    end else begin
      flg_q  <= cond_v | (flg_q & {NFLAG{~stat_rd}});
      drdy_q <= accept | (drdy_q & ~res_rd);
      if (accept) res_q <= res_data;
      if (wr_en) begin
        case (wr_addr)
          A_CTRL:  ctrl_q <= wr_data;
          A_OVR:   ovr_q  <= wr_data;
          A_UND:   und_q  <= wr_data;
          default: ;
        endcase
      end
    end
  end

  // R8
  flag_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_v != '0) |=> ((flg_q & $past(cond_v)) == $past(cond_v)));
  // R9
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((flg_q & $past(flg_q)) == $past(flg_q)));
  // R10
  drdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> drdy_q);
  // R11
  drdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drdy_q && !res_rd) |=> (drdy_q && $stable(res_q)));
endmodule

// File: rtl/sercmd_regif.sv
module sercmd_regif
  import sif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              csn,
  input  logic              mosi,
  output logic              miso,
  input  logic              result_valid,
  output logic              result_ready,
  input  logic [RES_W-1:0]  result_data,
  input  logic              lowbatt_cond,
  output logic [CTRL_W-1:0] ctrl_word
);
  logic [2:0]        pins_s;
  logic              rd_stb, wr_en;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [SR_W-1:0]   rd_data;
  logic [THR_W-1:0]  wr_data;

  sif_sync #(.STAGES(SYNC_STAGES), .W(3), .RST(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({csn, sclk, mosi}), .q(pins_s));

  sif_frame u_frame (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[1]), .csn_s(pins_s[2]), .mosi_s(pins_s[0]),
    .rd_data(rd_data), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .miso(miso));

  sif_regfile u_regs (
    .clk(clk), .rst_n(rst_n),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .res_valid(result_valid), .res_ready(result_ready), .res_data(result_data),
    .lowbatt(lowbatt_cond), .ctrl(ctrl_word));
endmodule

// File: tb/test_sercmd_regif.sv
module test_sercmd_regif;
  localparam int H = 6;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0, miso;
  logic result_valid = 1'b0, result_ready, lowbatt_cond = 1'b0;
  logic [23:0] result_data = '0;
  logic [15:0] ctrl_word;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [3:0] mf = '0;
  logic md = 1'b0;
  int cur_v = 0;

  always #4 clk = ~clk;

  sercmd_regif i_sercmd_regif (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .mosi(mosi), .miso(miso),
    .result_valid(result_valid), .result_ready(result_ready),
    .result_data(result_data), .lowbatt_cond(lowbatt_cond), .ctrl_word(ctrl_word));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nbits(input logic [4:0] a);
    if (a == 5'd4) return 24;
    if (a >= 5'd1 && a <= 5'd3) return 16;
    return 8;
  endfunction

  function automatic logic [3:0] cnd(input int v, input logic l);
    return {v < 0, v > 1000, v < -1000, l};
  endfunction

  task automatic sbit(input logic b, output logic r);
    mosi = b;
    tick(H);
    r = miso;
    sclk = 1'b1;
    tick(H);
    sclk = 1'b0;
  endtask

  task automatic txn(input int idle, input logic rd, input logic [4:0] a, input logic dc,
                     input int nb, input logic [23:0] wd, output logic [23:0] rv);
    logic r;
    rv = '0;
    for (int i = 0; i < idle; i++) sbit(1'b0, r);
    sbit(1'b1, r);
    sbit(rd, r);
    for (int i = 4; i >= 0; i--) sbit(a[i], r);
    sbit(dc, r);
    for (int i = nb - 1; i >= 0; i--) begin
      sbit(wd[i], r);
      rv = {rv[22:0], r};
    end
    mosi = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [23:0] rv);
    txn(0, 1'b1, a, 1'b0, nbits(a), 24'h0, rv);
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [23:0] wd);
    logic [23:0] d;
    txn(1, 1'b0, a, 1'b1, nbits(a), wd, d);
  endtask

  task automatic rd_stat(input string tag);
    logic [23:0] v;
    mf |= cnd(cur_v, lowbatt_cond);
    rd_reg(5'd0, v);
    chk(tag, v, {16'h0, mf, md, 3'b000});
    mf &= cnd(cur_v, lowbatt_cond);
  endtask

  task automatic push(input int v);
    while (!result_ready) tick(1);
    result_valid = 1'b1;
    result_data = 24'(v);
    tick(1);
    result_valid = 1'b0;
    tick(2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] v;
    int vals[10] = '{-2000, -1001, -1000, -999, 0, 999, 1000, 1001, -8388608, 8388607};
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R6 reset state at the pins
    chk("R6 ctrl_word", 24'(ctrl_word), 24'h000001);
    chk("R6 result_ready", 24'(result_ready), 24'h1);
    chk("R6 miso", 24'(miso), 24'h0);
    csn = 1'b0;
    tick(10);

    // R1 R2 R3 R6: every address, varied idle zeros and bit 0
    for (int a = 0; a < 32; a++) begin
      txn(a % 8, 1'b1, 5'(a), a[0], nbits(5'(a)), 24'h0, v);
      chk($sformatf("R1 R2 R6 addr %0d", a), v, (a == 1) ? 24'h1 : 24'h0);
      rd_reg(5'd1, v);
      chk($sformatf("R3 framing after addr %0d", a), v, 24'h1);
    end

    // R5 R13 R4: control patterns, MSB-first
    begin
      logic [15:0] pats[4] = '{16'hA5C3, 16'hFFFF, 16'h0000, 16'h8001};
      for (int i = 0; i < 4; i++) begin
        wr_reg(5'd1, 24'(pats[i]));
        tick(4);
        chk("R13 ctrl_word", 24'(ctrl_word), 24'(pats[i]));
        rd_reg(5'd1, v);
        chk("R4 R5 ctrl readback", v, 24'(pats[i]));
      end
    end
    wr_reg(5'd2, 24'h0003E8);
    wr_reg(5'd3, 24'h00FC18);
    rd_reg(5'd2, v);
    chk("R5 over threshold", v, 24'h0003E8);
    rd_reg(5'd3, v);
    chk("R5 under threshold", v, 24'h00FC18);

    // R5 read-only and unmapped writes ignored
    wr_reg(5'd0, 24'hFF);
    wr_reg(5'd4, 24'hABCDEF);
    wr_reg(5'd7, 24'h5A);
    wr_reg(5'd31, 24'hC3);
    rd_reg(5'd1, v);
    chk("R5 ctrl after RO writes", v, 24'h008001);
    rd_reg(5'd2, v);
    chk("R5 over after RO writes", v, 24'h0003E8);
    rd_reg(5'd4, v);
    chk("R5 result after RO write", v, 24'h0);
    rd_stat("R5 R7 status after RO write");

    // R7 R8 R9 R10 R11: threshold sweep
    foreach (vals[k]) begin
      push(vals[k]);
      cur_v = vals[k];
      md = 1'b1;
      chk("R11 ready low while unread", 24'(result_ready), 24'h0);
      rd_stat("R7 R8 status after result");
      rd_stat("R9 R10 status re-read");
      rd_reg(5'd4, v);
      chk("R4 result readback", v, 24'(vals[k]));
      md = 1'b0;
      tick(2);
      chk("R10 R11 ready after result read", 24'(result_ready), 24'h1);
      rd_stat("R9 R10 status after result read");
    end

    // R8 R9 low battery stickiness
    lowbatt_cond = 1'b1;
    tick(3);
    rd_stat("R8 low battery set");
    rd_stat("R9 low battery held");
    lowbatt_cond = 1'b0;
    tick(3);
    rd_stat("R9 low battery sticky");
    rd_stat("R9 low battery cleared");

    // R11 back-pressure
    push(100);
    cur_v = 100;
    md = 1'b1;
    result_valid = 1'b1;
    result_data = 24'hFFFFFB;
    tick(20);
    chk("R11 ready held low", 24'(result_ready), 24'h0);
    rd_stat("R10 R11 blocked result");
    rd_reg(5'd4, v);
    chk("R11 first result kept", v, 24'd100);
    tick(4);
    chk("R11 second result taken", 24'(result_ready), 24'h0);
    result_valid = 1'b0;
    cur_v = -5;
    rd_reg(5'd4, v);
    chk("R11 second result value", v, 24'hFFFFFB);
    md = 1'b0;
    rd_stat("R8 sign of second result");

    // R12 abort in data phase and in command byte
    begin
      logic r;
      sbit(1'b1, r); sbit(1'b0, r);
      for (int i = 4; i >= 0; i--) sbit(i == 0, r);
      sbit(1'b0, r);
      for (int i = 0; i < 8; i++) sbit(1'b1, r);
      csn = 1'b1;
      tick(10);
      chk("R12 miso idle after abort", 24'(miso), 24'h0);
      csn = 1'b0;
      tick(10);
      rd_reg(5'd1, v);
      chk("R12 no commit on abort", v, 24'h008001);
      sbit(1'b1, r); sbit(1'b0, r); sbit(1'b1, r);
      csn = 1'b1;
      tick(10);
      csn = 1'b0;
      tick(10);
      rd_reg(5'd1, v);
      chk("R12 hunt restarts after abort", v, 24'h008001);
      chk("R13 ctrl_word after abort", 24'(ctrl_word), 24'h008001);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule